// File: doc/BRIEF.md
# I2C Master Command and Receive Queue Front-End

This block sits between a software register port and the bit-level engine of an I2C master. Software queues bus operations by writing one data/command address: every accepted write becomes one entry in a transmit command queue. An entry is either a byte to send or a request to read one byte from the bus. Bytes that the engine receives land in a receive queue, and software takes them out by reading the same address. The queue levels and two programmable thresholds drive level-type interrupt flags. Misuse of either queue sets sticky error flags, which software clears by writing ones.

The engine side is two streams. The command stream (`cmd_valid`/`cmd_ready`/`cmd_data`) follows valid/ready rules. `cmd_valid` is high exactly while the transmit queue holds an entry. `cmd_data` shows the oldest entry and holds steady until the engine accepts it with `cmd_ready` high at a clock edge. The receive stream (`rx_valid`/`rx_ready`/`rx_data`) never applies back-pressure: `rx_ready` is tied high. A byte offered while the receive queue is full is dropped and flagged instead of stalling the engine. A one-cycle `xfer_abort` pulse from the engine empties both queues at the next edge.

Register word addresses on `reg_addr`:
- 0: data/command.
- 1: transmit level.
- 2: receive level.
- 3: transmit threshold.
- 4: receive threshold.
- 5: flags.
- 6: depths.

Reads are combinational from `reg_addr`. A read or write takes effect at the clock edge where `reg_rd` or `reg_wr` is high.

Top module: `i2cq_front`

## Requirements
- R1: A write to address 0 with `reg_wdata[8]`=0 queues the entry {0, `reg_wdata[7:0]`}. A write with `reg_wdata[8]`=1 queues a read request, {1, 8'h00}. Entries leave on `cmd_data[8:0]` in write order.
- R2: With `reg_rd` high at address 0, `reg_rdata[7:0]` shows the oldest received byte (upper bits zero), and that byte is removed at the edge.
- R3: Address 1 reads the transmit queue occupancy and address 2 reads the receive queue occupancy; both are 0 after reset.
- R4: The thresholds at addresses 3 and 4 are read/write and reset to 0. `irq_tx_empty` (flags bit 0) is high exactly while transmit level <= transmit threshold.
- R5: `irq_rx_full` (flags bit 1) is high exactly while receive level > receive threshold.
- R6: A data write while the transmit queue is full is dropped: the level and contents stay unchanged, and sticky `irq_tx_over` (flags bit 2) is set.
- R7: A data read while the receive queue is empty returns 0 and sets sticky `irq_rx_under` (flags bit 3).
- R8: `rx_ready` is always 1. A received byte offered while the receive queue is full is dropped and sets sticky `irq_rx_over` (flags bit 4).
- R9: `xfer_abort` empties both queues at the next edge, discarding any push in the same cycle. The sticky flags are not changed by it.
- R10: A write to address 5 clears each sticky flag whose bit in `reg_wdata` is 1. A new error event in the same cycle wins over the clear.
- R11: Address 6 reads {receive depth[15:0], transmit depth[15:0]}; both are 8 by default.
- R12: `cmd_valid` is high exactly while the transmit level is nonzero. While `cmd_valid` is high and `cmd_ready` is low, `cmd_data` holds until acceptance or abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops at address 0) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| cmd_valid | output | 1 | Command entry available |
| cmd_ready | input | 1 | Engine accepts the command entry |
| cmd_data | output | 9 | Bit 8 read request, bits 7:0 byte to send |
| rx_valid | input | 1 | Received byte offered |
| rx_ready | output | 1 | Always 1 |
| rx_data | input | 8 | Received byte |
| xfer_abort | input | 1 | Abort pulse, flushes both queues |
| irq_tx_empty | output | 1 | Transmit level at or below threshold |
| irq_rx_full | output | 1 | Receive level above threshold |
| irq_tx_over | output | 1 | Sticky: write dropped on full transmit queue |
| irq_rx_under | output | 1 | Sticky: read of empty receive queue |
| irq_rx_over | output | 1 | Sticky: received byte dropped |

## Verification
A register read returns its value in the same cycle as the strobe. Levels, level flags and sticky flags reflect an operation from the clock edge that ends its strobe cycle, so they are due one edge after the stimulus. The bench drives every input on the falling edge and samples just after it, so each stimulus is seen by exactly one rising edge and each result is read in the cycle after that edge. A scoreboard queue holds the command entries that the written sequence should produce. An engine-side monitor compares each entry in the cycle of its handshake.

// File: rtl/i2cq_pkg.sv
package i2cq_pkg;

  localparam int unsigned REG_AW  = 3;
  localparam int unsigned REG_DW  = 32;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned CMD_W   = BYTE_W + 1;
  localparam int unsigned RD_BIT  = BYTE_W;

  typedef enum logic [REG_AW-1:0] {
    RA_DATA  = 3'd0,
    RA_TXLVL = 3'd1,
    RA_RXLVL = 3'd2,
    RA_TXTHR = 3'd3,
    RA_RXTHR = 3'd4,
    RA_FLAGS = 3'd5,
    RA_DEPTH = 3'd6
  } reg_addr_e;

  localparam int unsigned FLAG_W   = 5;
  localparam int unsigned FB_TXE   = 0;
  localparam int unsigned FB_RXF   = 1;
  localparam int unsigned FB_TXOVR = 2;
  localparam int unsigned FB_RXUND = 3;
  localparam int unsigned FB_RXOVR = 4;
  localparam int unsigned STICKY_N = 3;
  localparam int unsigned STICKY_LO = FB_TXOVR;

endpackage

// File: rtl/i2cq_fifo.sv
module i2cq_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [CW-1:0]    count,
  output logic             full,
  output logic             empty
);

  logic [WIDTH-1:0] slot [DEPTH];
  logic [PW-1:0]    wr_ptr, rd_ptr;
  logic             do_push, do_pop;

  function automatic logic [PW-1:0] ptr_step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign head    = slot[rd_ptr];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot[i] <= '0;
      end else if (do_push && (wr_ptr == PW'(i))) begin
        slot[i] <= push_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_step(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_step(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/i2cq_flags.sv
module i2cq_flags
  import i2cq_pkg::*;
#(
  parameter int unsigned TXCW = 4,
  parameter int unsigned RXCW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TXCW-1:0]   tx_level,
  input  logic [TXCW-1:0]   tx_thr,
  input  logic [RXCW-1:0]   rx_level,
  input  logic [RXCW-1:0]   rx_thr,
  input  logic [STICKY_N-1:0] err_set,
  input  logic [STICKY_N-1:0] err_clr,
  output logic [FLAG_W-1:0] flags
);

  logic [STICKY_N-1:0] sticky;

  for (genvar i = 0; i < STICKY_N; i++) begin : g_sticky
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sticky[i] <= 1'b0;
      end else if (err_set[i]) begin
        sticky[i] <= 1'b1;
      end else if (err_clr[i]) begin
        sticky[i] <= 1'b0;
      end
    end
  end

  always_comb begin
    flags = '0;
    flags[FB_TXE] = (tx_level <= tx_thr);
    flags[FB_RXF] = (rx_level > rx_thr);
    flags[STICKY_LO +: STICKY_N] = sticky;
  end

endmodule

// File: rtl/i2cq_front.sv
module i2cq_front
  import i2cq_pkg::*;
#(
  parameter int unsigned TX_DEPTH = 8,
  parameter int unsigned RX_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [CMD_W-1:0]  cmd_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              xfer_abort,
  output logic              irq_tx_empty,
  output logic              irq_rx_full,
  output logic              irq_tx_over,
  output logic              irq_rx_under,
  output logic              irq_rx_over
);

  localparam int unsigned TXCW = $clog2(TX_DEPTH + 1);
  localparam int unsigned RXCW = $clog2(RX_DEPTH + 1);
  localparam int unsigned HALF = REG_DW / 2;

  logic [TXCW-1:0]   tx_count, tx_thr;
  logic [RXCW-1:0]   rx_count, rx_thr;
  logic              tx_full, tx_empty, rx_full, rx_empty;
  logic [BYTE_W-1:0] rx_head;
  logic [CMD_W-1:0]  new_cmd;
  logic              data_wr, data_rd, tx_push, rx_pop;
  logic [STICKY_N-1:0] err_set, err_clr;
  logic [FLAG_W-1:0] flags;

  // Register decode
  assign data_wr = reg_wr && (reg_addr == RA_DATA);
  assign data_rd = reg_rd && (reg_addr == RA_DATA);
  assign tx_push = data_wr && !tx_full;
  assign rx_pop  = data_rd && !rx_empty;
  assign new_cmd = reg_wdata[RD_BIT] ? {1'b1, {BYTE_W{1'b0}}}
                                     : {1'b0, reg_wdata[BYTE_W-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_thr <= '0;
      rx_thr <= '0;
    end else if (reg_wr) begin
      if (reg_addr == RA_TXTHR) tx_thr <= reg_wdata[TXCW-1:0];
      if (reg_addr == RA_RXTHR) rx_thr <= reg_wdata[RXCW-1:0];
    end
  end

  // Queues
  i2cq_fifo #(.WIDTH(CMD_W), .DEPTH(TX_DEPTH)) u_txq (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (xfer_abort),
    .push      (tx_push),
    .push_data (new_cmd),
    .pop       (cmd_valid && cmd_ready),
    .head      (cmd_data),
    .count     (tx_count),
    .full      (tx_full),
    .empty     (tx_empty)
  );

  i2cq_fifo #(.WIDTH(BYTE_W), .DEPTH(RX_DEPTH)) u_rxq (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (xfer_abort),
    .push      (rx_valid),
    .push_data (rx_data),
    .pop       (rx_pop),
    .head      (rx_head),
    .count     (rx_count),
    .full      (rx_full),
    .empty     (rx_empty)
  );

  assign cmd_valid = !tx_empty;
  assign rx_ready  = 1'b1;

  // Flags
  assign err_set[FB_TXOVR-STICKY_LO] = data_wr && tx_full;
  assign err_set[FB_RXUND-STICKY_LO] = data_rd && rx_empty;
  assign err_set[FB_RXOVR-STICKY_LO] = rx_valid && rx_full;
  assign err_clr = (reg_wr && (reg_addr == RA_FLAGS))
                 ? reg_wdata[STICKY_LO +: STICKY_N] : '0;

  i2cq_flags #(.TXCW(TXCW), .RXCW(RXCW)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_level (tx_count),
    .tx_thr   (tx_thr),
    .rx_level (rx_count),
    .rx_thr   (rx_thr),
    .err_set  (err_set),
    .err_clr  (err_clr),
    .flags    (flags)
  );

  assign irq_tx_empty = flags[FB_TXE];
  assign irq_rx_full  = flags[FB_RXF];
  assign irq_tx_over  = flags[FB_TXOVR];
  assign irq_rx_under = flags[FB_RXUND];
  assign irq_rx_over  = flags[FB_RXOVR];

  // Read mux
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_DATA:  reg_rdata = rx_empty ? '0 : REG_DW'(rx_head);
      RA_TXLVL: reg_rdata = REG_DW'(tx_count);
      RA_RXLVL: reg_rdata = REG_DW'(rx_count);
      RA_TXTHR: reg_rdata = REG_DW'(tx_thr);
      RA_RXTHR: reg_rdata = REG_DW'(rx_thr);
      RA_FLAGS: reg_rdata = REG_DW'(flags);
      RA_DEPTH: reg_rdata = {HALF'(RX_DEPTH), HALF'(TX_DEPTH)};
      default:  reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/i2cq_front_chk.sv
module i2cq_front_chk
  import i2cq_pkg::*;
#(
  parameter int unsigned TX_DEPTH = 8,
  parameter int unsigned RX_DEPTH = 8,
  localparam int unsigned TXCW = $clog2(TX_DEPTH + 1),
  localparam int unsigned RXCW = $clog2(RX_DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [REG_AW-1:0] reg_addr,
  input logic [REG_DW-1:0] reg_rdata,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [CMD_W-1:0]  cmd_data,
  input logic              rx_valid,
  input logic              xfer_abort,
  input logic              irq_tx_empty,
  input logic              irq_tx_over,
  input logic              irq_rx_under,
  input logic              irq_rx_over,
  input logic [TXCW-1:0]   tx_count,
  input logic [TXCW-1:0]   tx_thr,
  input logic [RXCW-1:0]   rx_count
);

  // R9
  flush_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_abort |=> (tx_count == '0) && (rx_count == '0));

  // R12
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready && !xfer_abort) |=> cmd_valid && $stable(cmd_data));

  // R12
  cmd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid == (tx_count != '0));

  // R6
  tx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == RA_DATA && tx_count == TXCW'(TX_DEPTH)
     && !(cmd_valid && cmd_ready) && !xfer_abort)
    |=> irq_tx_over && (tx_count == TXCW'(TX_DEPTH)));

  // R7
  rx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == RA_DATA && rx_count == '0)
    |-> (reg_rdata == '0) ##1 irq_rx_under);

  // R8
  rx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_count == RXCW'(RX_DEPTH)
     && !(reg_rd && reg_addr == RA_DATA) && !xfer_abort)
    |=> irq_rx_over && (rx_count == RXCW'(RX_DEPTH)));

  // R4
  txe_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tx_empty == (tx_count <= tx_thr));

  // R3
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count <= TXCW'(TX_DEPTH)) && (rx_count <= RXCW'(RX_DEPTH)));

endmodule

bind i2cq_front i2cq_front_chk #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_wr       (reg_wr),
  .reg_rd       (reg_rd),
  .reg_addr     (reg_addr),
  .reg_rdata    (reg_rdata),
  .cmd_valid    (cmd_valid),
  .cmd_ready    (cmd_ready),
  .cmd_data     (cmd_data),
  .rx_valid     (rx_valid),
  .xfer_abort   (xfer_abort),
  .irq_tx_empty (irq_tx_empty),
  .irq_tx_over  (irq_tx_over),
  .irq_rx_under (irq_rx_under),
  .irq_rx_over  (irq_rx_over),
  .tx_count     (tx_count),
  .tx_thr       (tx_thr),
  .rx_count     (rx_count)
);

// File: tb/i2cq_front_bench.sv
`timescale 1ns/1ps
module i2cq_front_bench;

  localparam int TXD = 8;
  localparam int RXD = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        cmd_valid, cmd_ready = 1'b0;
  logic [8:0]  cmd_data;
  logic        rx_valid = 1'b0, rx_ready;
  logic [7:0]  rx_data = '0;
  logic        xfer_abort = 1'b0;
  logic        irq_tx_empty, irq_rx_full, irq_tx_over, irq_rx_under, irq_rx_over;

  int checks = 0, fails = 0, matched = 0;
  logic [8:0] exp_cmd[$];
  logic [7:0] exp_rx[$];

  always #2.5 clk = ~clk;

  i2cq_front #(.TX_DEPTH(TXD), .RX_DEPTH(RXD)) u_i2cq_front (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .xfer_abort(xfer_abort), .irq_tx_empty(irq_tx_empty),
    .irq_rx_full(irq_rx_full), .irq_tx_over(irq_tx_over),
    .irq_rx_under(irq_rx_under), .irq_rx_over(irq_rx_over));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    if (a == 3'd0 && exp_cmd.size() < TXD)
      exp_cmd.push_back(d[8] ? 9'h100 : {1'b0, d[7:0]});
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(posedge clk); #1;
    reg_rd = 1'b0;
  endtask

  task automatic rx_send(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    if (exp_rx.size() < RXD) exp_rx.push_back(b);
    @(posedge clk); #1;
    rx_valid = 1'b0;
  endtask

  task automatic pop_rx_check(input string req);
    logic [31:0] d;
    logic [7:0]  e;
    e = exp_rx.pop_front();
    reg_read(3'd0, d);
    check(req, d, {24'h0, e});
  endtask

  task automatic drain_tx;
    @(negedge clk) cmd_ready = 1'b1;
    while (exp_cmd.size() != 0) @(negedge clk);
    @(negedge clk) cmd_ready = 1'b0;
  endtask

  // Monitor: compares each handshaked command against the scoreboard
  initial forever begin
    @(negedge clk); #1;
    if (rst_n && cmd_valid && cmd_ready) begin
      checks++;
      if (exp_cmd.size() == 0) begin
        fails++;
        $display("FAIL R1: actual %h expected none", cmd_data);
      end else begin
        logic [8:0] e;
        e = exp_cmd.pop_front();
        if (cmd_data !== e) begin
          fails++;
          $display("FAIL R1: actual %h expected %h", cmd_data, e);
        end else matched++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;

    // Reset state
    reg_read(3'd1, d); check("R3 tx level reset", d, 0);
    reg_read(3'd2, d); check("R3 rx level reset", d, 0);
    reg_read(3'd5, d); check("R4 flags reset", d, 32'h1);
    reg_read(3'd6, d); check("R11 depths", d, {16'd8, 16'd8});
    reg_read(3'd3, d); check("R4 tx thr reset", d, 0);
    check("R12 no valid when empty", {31'h0, cmd_valid}, 0);
    check("R8 rx_ready high", {31'h0, rx_ready}, 1);

    // Mixed commands, engine stalled
    reg_write(3'd0, 32'h0A5);
    reg_write(3'd0, 32'h100);
    reg_write(3'd0, 32'h03C);
    reg_write(3'd0, 32'h1FF);
    reg_read(3'd1, d); check("R3 tx level 4", d, 4);
    check("R12 valid when nonempty", {31'h0, cmd_valid}, 1);
    check("R4 tx_empty low above thr", {31'h0, irq_tx_empty}, 0);
    reg_write(3'd3, 7);
    reg_read(3'd3, d); check("R4 tx thr readback", d, 7);
    check("R4 tx_empty at 4<=7", {31'h0, irq_tx_empty}, 1);
    reg_write(3'd3, 3);
    check("R4 tx_empty 4>3", {31'h0, irq_tx_empty}, 0);
    reg_write(3'd3, 4);
    check("R4 tx_empty 4<=4", {31'h0, irq_tx_empty}, 1);

    // Fill and overflow
    for (int i = 0; i < 4; i++) reg_write(3'd0, 32'h10 + i);
    reg_read(3'd1, d); check("R3 tx level full", d, 8);
    check("R6 no over yet", {31'h0, irq_tx_over}, 0);
    reg_write(3'd0, 32'h77);
    reg_read(3'd1, d); check("R6 level unchanged", d, 8);
    check("R6 tx_over set", {31'h0, irq_tx_over}, 1);
    reg_write(3'd5, 32'h4);
    check("R10 tx_over cleared", {31'h0, irq_tx_over}, 0);

    // Drain through the engine
    drain_tx();
    reg_read(3'd1, d); check("R3 tx level drained", d, 0);
    check("R1 all eight entries matched", matched, 8);

    // Receive path
    rx_send(8'h11); rx_send(8'h22); rx_send(8'h33);
    reg_read(3'd2, d); check("R3 rx level 3", d, 3);
    check("R5 rx_full 3>0", {31'h0, irq_rx_full}, 1);
    reg_write(3'd4, 3);
    check("R5 rx_full 3>3 false", {31'h0, irq_rx_full}, 0);
    reg_write(3'd4, 2);
    check("R5 rx_full 3>2", {31'h0, irq_rx_full}, 1);
    for (int i = 0; i < 3; i++) pop_rx_check("R2 rx order");
    reg_read(3'd2, d); check("R3 rx level empty", d, 0);
    reg_read(3'd0, d); check("R7 empty read zero", d, 0);
    check("R7 rx_under set", {31'h0, irq_rx_under}, 1);
    reg_write(3'd5, 32'h8);
    check("R10 rx_under cleared", {31'h0, irq_rx_under}, 0);

    // Receive overflow
    for (int i = 0; i < 9; i++) rx_send(8'h40 + 8'(i));
    reg_read(3'd2, d); check("R8 rx level full", d, 8);
    check("R8 rx_over set", {31'h0, irq_rx_over}, 1);
    for (int i = 0; i < 8; i++) pop_rx_check("R8 oldest kept");

    // Abort flushes both queues, sticky flag kept
    reg_write(3'd0, 32'h0C1);
    reg_write(3'd0, 32'h0C2);
    rx_send(8'h99); rx_send(8'h98);
    @(negedge clk) xfer_abort = 1'b1;
    @(posedge clk); #1 xfer_abort = 1'b0;
    exp_cmd.delete(); exp_rx.delete();
    reg_read(3'd1, d); check("R9 tx flushed", d, 0);
    reg_read(3'd2, d); check("R9 rx flushed", d, 0);
    check("R9 sticky kept", {31'h0, irq_rx_over}, 1);
    check("R9 no command after flush", {31'h0, cmd_valid}, 0);
    reg_write(3'd0, 32'h05A);
    check("R9 new head after flush", {23'h0, cmd_data}, 32'h05A);
    drain_tx();
    check("R9 post-abort entry matched", matched, 9);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule